// File: doc/BRIEF.md
# Streamed Square-Wave Generator

The block drives one output pin with a square wave whose every cycle can have its own length. The length comes from a stream of 32-bit words written through a valid/ready port into an eight-word FIFO. Each word carries four 8-bit delay values, and each value sets one whole output cycle. The pin is high for the value plus a fixed overhead of system clocks, then low for the same number of clocks. The values are used from the top byte down.

An upstream agent computes the delays and keeps the FIFO fed. While words are available, each half-period is exact to the clock, and a word boundary costs no extra cycles. If the FIFO runs dry at a word boundary, the pin stays low until a word arrives. An enable input stops generation and drives the pin low. Stopping drops the rest of the word in progress and leaves the FIFO contents untouched.

Top module: `sqwave_stream`

## Requirements
- R1: After reset `wave_out` is 0 and `in_ready` is 1.
- R2: A word is stored when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high exactly while fewer than 8 words are held. A word offered while 8 are held is dropped and never produces output.
- R3: The four delay fields of a word are used in the order bits 31:24, 23:16, 15:8, 7:0.
- R4: For a field of value v, `wave_out` is high for exactly v+5 clocks and then low for exactly v+5 clocks. So v=0 gives 5 clocks per phase and v=255 gives 260.
- R5: While the FIFO is not empty, the high phase of the next field starts on the clock right after the previous low phase ends, within a word and across word boundaries.
- R6: If the FIFO is empty when a word's last low phase ends, `wave_out` stays low until a word is stored. That word then starts with its top field.
- R7: When `en` is low, `wave_out` is 0 from the next clock. The rest of the current word is discarded and stored words are kept. Once `en` returns, generation resumes with the top field of the next stored word.
- R8: While `en` is low, no word is taken from the FIFO, and words can still be stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generation enable |
| in_valid | input | 1 | Word offered on `in_word` |
| in_ready | output | 1 | FIFO can store a word |
| in_word | input | 32 | Four packed delay fields, top byte first |
| wave_out | output | 1 | Square-wave output |

## Verification
The bench measures every high and low run of `wave_out` in clocks and compares it with v+5 for the field expected next. The expected field comes from the order in which the bench stored its words. Because of this, each kind of internal fault shows up at the pin within one output cycle:
- A delay counter that is off by one changes the length of the run in progress.
- A wrong field pointer or shift plays the wrong byte.
- A lost or duplicated FIFO entry leaves a run that matches no expected field, or leaves expected fields unplayed when the stream drains.

Faults in the full flag or the enable handling appear the same way, through an extra or missing cycle after the bench drains the stream.

// File: rtl/sqwave_stream.sv
module sqwave_stream #(
  parameter int WORD_W   = 32,
  parameter int FIELD_W  = 8,
  parameter int DEPTH    = 8,
  parameter int OVERHEAD = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              wave_out
);
  localparam int NFIELD = WORD_W / FIELD_W;
  localparam int IW     = (NFIELD > 1) ? $clog2(NFIELD) : 1;
  localparam int CW     = $clog2((1 << FIELD_W) + OVERHEAD);
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW     = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [NW-1:0]     count;
  logic [WORD_W-1:0] sh;
  logic [IW-1:0]     idx;
  logic [CW-1:0]     cnt;
  logic              busy;

  wire nonempty = (count != '0);
  wire push     = in_valid && in_ready;
  wire last_fld = (idx == IW'(NFIELD - 1));
  wire end_low  = busy && (cnt == '0) && !wave_out;
  wire pop      = en && nonempty && (!busy || (end_low && last_fld));

  wire [WORD_W-1:0]  head     = mem[rptr];
  wire [FIELD_W-1:0] head_fld = head[WORD_W-1 -: FIELD_W];
  wire [FIELD_W-1:0] cur_fld  = sh[WORD_W-1 -: FIELD_W];
  wire [FIELD_W-1:0] nxt_fld  = sh[WORD_W-FIELD_W-1 -: FIELD_W];

  assign in_ready = (count < NW'(DEPTH));

  function automatic logic [CW-1:0] span(input logic [FIELD_W-1:0] v);
    return CW'(v) + CW'(OVERHEAD - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= in_word;
        wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      end
      if (pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + NW'(push) - NW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wave_out <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      sh       <= '0;
    end else if (!en) begin
      busy     <= 1'b0;
      wave_out <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
    end else if (!busy || end_low && last_fld) begin
      if (nonempty) begin
        busy     <= 1'b1;
        sh       <= head;
        idx      <= '0;
        wave_out <= 1'b1;
        cnt      <= span(head_fld);
      end else begin
        busy <= 1'b0;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (wave_out) begin
      wave_out <= 1'b0;
      cnt      <= span(cur_fld);
    end else begin
      idx      <= idx + 1'b1;
      sh       <= sh << FIELD_W;
      wave_out <= 1'b1;
      cnt      <= span(nxt_fld);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));

  assert_full_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == NW'(DEPTH)) |=> (count <= $past(count)));

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy && cnt != '0) |=> $stable(wave_out));

  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wave_out);

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wave_out);

  assert_off_keeps_fifo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !in_valid) |=> $stable(count));
endmodule

// File: tb/sqwave_stream_bench.sv
module sqwave_stream_bench;
  logic clk = 0, rst_n = 0, en = 0, in_valid = 0;
  logic [31:0] in_word = '0;
  logic in_ready, wave_out;

  sqwave_stream u_sqwave_stream (.clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .wave_out(wave_out));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  int exp_q[$];
  bit mon_on = 1, strict = 1, have_prev = 0;
  logic prev_w = 0;
  int run = 0, cur = 0, prev_fld = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int phase_len(input int v);
    return v + 5;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (wave_out === prev_w) run++;
      else begin
        if (mon_on) begin
          if (wave_out) begin
            if (have_prev && strict)
              chk(run == phase_len(prev_fld), "R5 low run", run, phase_len(prev_fld));
            if (exp_q.size() == 0) begin
              chk(0, "R2 unexpected cycle", 1, 0);
              cur = -100;
            end else cur = exp_q.pop_front();
          end else begin
            chk(run == phase_len(cur), "R4 R3 high run", run, phase_len(cur));
            prev_fld = cur;
            have_prev = 1;
          end
        end
        run = 1;
      end
      prev_w = wave_out;
    end
  end

  task automatic push(input logic [31:0] w);
    while (!in_ready) @(negedge clk);
    in_valid = 1;
    in_word = w;
    for (int k = 3; k >= 0; k--) exp_q.push_back(int'(w[k*8 +: 8]));
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    while (wave_out) @(negedge clk);
    repeat (300) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(wave_out == 0, "R1 wave_out", wave_out, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);

    push(32'h00FF_0180);
    push(32'hFF00_0203);
    for (int i = 0; i < 6; i++) push($urandom);
    chk(in_ready == 0, "R2 full", in_ready, 0);
    chk(wave_out == 0, "R8 low while off", wave_out, 0);
    in_valid = 1;
    in_word = 32'h1111_1111;
    repeat (3) @(negedge clk);
    in_valid = 0;
    chk(in_ready == 0, "R2 still full", in_ready, 0);

    have_prev = 0;
    strict = 1;
    en = 1;
    for (int i = 0; i < 20; i++) push($urandom);
    drain();
    chk(exp_q.size() == 0, "R2 R8 all played", exp_q.size(), 0);
    chk(wave_out == 0, "R6 low when empty", wave_out, 0);

    strict = 0;
    push({8'd3, 8'd7, 8'd0, 8'd1});
    drain();
    push({8'd200, 8'd9, 8'd40, 8'd2});
    drain();
    chk(exp_q.size() == 0, "R6 resume", exp_q.size(), 0);

    mon_on = 0;
    en = 0;
    @(negedge clk);
    exp_q.delete();
    push({8'd16, 8'd30, 8'd50, 8'd70});
    push({8'd4, 8'd100, 8'd6, 8'd11});
    en = 1;
    @(posedge wave_out);
    @(posedge wave_out);
    repeat (3) @(negedge clk);
    chk(wave_out == 1, "R7 precondition high", wave_out, 1);
    en = 0;
    @(negedge clk);
    chk(wave_out == 0, "R7 low next clock", wave_out, 0);
    repeat (20) @(negedge clk);
    chk(wave_out == 0, "R7 stays low", wave_out, 0);
    chk(in_ready == 1, "R8 fifo kept", in_ready, 1);
    exp_q.delete();
    exp_q.push_back(4); exp_q.push_back(100); exp_q.push_back(6); exp_q.push_back(11);
    have_prev = 0;
    strict = 1;
    mon_on = 1;
    en = 1;
    drain();
    chk(exp_q.size() == 0, "R7 next word only", exp_q.size(), 0);
    chk(wave_out == 0, "R6 final low", wave_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule